// File: doc/BRIEF.md
# Two-Level I/O Address Translation Walker

This block turns a 32-bit I/O virtual address into a physical address. It reads descriptors from a two-level translation table held in memory. A requester presents an address together with the base of the level-one table. It issues the request when the walker reports that it is idle. The walker then fetches one descriptor word at a time through a simple read-request / read-response port. A level-one descriptor either maps a 1 MiB section directly, points to a level-two table, or marks a fault. A level-two descriptor maps a 4 KiB small page or a 64 KiB large page, or marks a fault.

The walk ends with a one-cycle completion pulse. The result registers then hold either the physical address or a fault flag. A fault also reports the level that faulted and the virtual address that caused it, so that a separate register block can capture them. Caching of translations, permission checks and interrupt generation are left to neighbouring blocks.

Top module: `ptw_walker`

## Requirements
- R1: After reset the walker is idle: `req_ready` is 1, and `done` and `mem_rd_en` are 0.
- R2: A request is taken only when `req_valid` and `req_ready` are both 1. One cycle later `mem_rd_en` pulses with address {`tbl_base`[31:14], `req_va`[31:20], 2'b00}. Bits [13:0] of `tbl_base` are ignored.
- R3: A level-one descriptor whose bits [1:0] are 2'b10 is a section. The result is `pa` = {desc[31:20], va[19:0]} with `fault` = 0.
- R4: A level-one descriptor whose bits [1:0] are 2'b00 or 2'b11 ends the walk with `fault` = 1, `fault_stage` = 0 and `fault_va` = the request address.
- R5: A level-one descriptor whose bits [1:0] are 2'b01 starts a second read one cycle later, at address {desc[31:10], va[19:12], 2'b00}.
- R6: A level-two descriptor with bit 1 set is a small page. The result is `pa` = {desc[31:12], va[11:0]}.
- R7: A level-two descriptor whose bits [1:0] are 2'b01 is a large page. The result is `pa` = {desc[31:16], va[15:0]}, whichever of the sixteen replicated entries is indexed.
- R8: A level-two descriptor whose bits [1:0] are 2'b00 ends the walk with `fault` = 1, `fault_stage` = 1 and `fault_va` = the request address.
- R9: At most one read is outstanding. `mem_rd_en` is a single-cycle pulse, and no new read is issued before the response to the previous one.
- R10: `done` pulses for exactly one cycle, one cycle after the final response. The result outputs hold their values until the next `done`.
- R11: `req_valid` during a walk and `mem_rd_valid` while idle have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request strobe |
| req_va | input | 32 | Virtual address to translate |
| tbl_base | input | 32 | Level-one table base (16 KiB aligned) |
| req_ready | output | 1 | Walker idle, request may be issued |
| mem_rd_en | output | 1 | Descriptor read request pulse |
| mem_rd_addr | output | 32 | Descriptor word address |
| mem_rd_valid | input | 1 | Read response strobe |
| mem_rd_data | input | 32 | Descriptor word returned |
| done | output | 1 | Walk complete pulse |
| pa | output | 32 | Translated physical address (valid when not faulted) |
| fault | output | 1 | Walk ended in a translation fault |
| fault_stage | output | 1 | Faulting level: 0 level one, 1 level two |
| fault_va | output | 32 | Virtual address that faulted |

## Verification
The assertions assume that memory answers each read exactly once, with a single-cycle `mem_rd_valid`, at least one cycle after the `mem_rd_en` pulse. They also assume that no stray response arrives while a read is pending. The bench memory model keeps to this contract: it answers every observed read after a fixed latency and drops the strobe after one cycle. The only responses that break the contract are the deliberate ones the bench injects while the walker is idle, and the design must ignore those.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  localparam int VA_W        = 32;
  localparam int L1_IDX_LSB  = 20;
  localparam int L1_BASE_LSB = 14;
  localparam int L2_IDX_LSB  = 12;
  localparam int L2_BASE_LSB = 10;
  localparam int LARGE_LSB   = 16;

  typedef enum logic [1:0] {L1K_FAULT, L1K_SECTION, L1K_LINK} l1_kind_t;
  typedef enum logic [1:0] {L2K_FAULT, L2K_LARGE, L2K_SMALL} l2_kind_t;
  typedef enum logic [1:0] {ST_IDLE, ST_LVL1, ST_LVL2} walk_state_t;

  function automatic logic [VA_W-1:0] l1_entry_addr(input logic [VA_W-1:0] base,
                                                    input logic [VA_W-1:0] va);
    return {base[VA_W-1:L1_BASE_LSB], va[VA_W-1:L1_IDX_LSB], 2'b00};
  endfunction

  function automatic logic [VA_W-1:0] l2_entry_addr(input logic [VA_W-1:0] desc,
                                                    input logic [VA_W-1:0] va);
    return {desc[VA_W-1:L2_BASE_LSB], va[L1_IDX_LSB-1:L2_IDX_LSB], 2'b00};
  endfunction

  function automatic logic [VA_W-1:0] join_pa(input logic [VA_W-1:0] desc,
                                              input logic [VA_W-1:0] va,
                                              input int unsigned lsb);
    logic [VA_W-1:0] m;
    m = ({VA_W{1'b1}} << lsb);
    return (desc & m) | (va & ~m);
  endfunction

endpackage

// File: rtl/ptw_l1_decode.sv
module ptw_l1_decode
  import ptw_pkg::*;
(
  input  logic [VA_W-1:0] desc,
  input  logic [VA_W-1:0] va,
  output l1_kind_t        kind,
  output logic [VA_W-1:0] sect_pa,
  output logic [VA_W-1:0] next_addr
);
  always_comb begin
    unique case (desc[1:0])
      2'b10:   kind = L1K_SECTION;
      2'b01:   kind = L1K_LINK;
      default: kind = L1K_FAULT;
    endcase
  end

  assign sect_pa   = join_pa(desc, va, L1_IDX_LSB);
  assign next_addr = l2_entry_addr(desc, va);
endmodule

// File: rtl/ptw_l2_decode.sv
module ptw_l2_decode
  import ptw_pkg::*;
(
  input  logic [VA_W-1:0] desc,
  input  logic [VA_W-1:0] va,
  output l2_kind_t        kind,
  output logic [VA_W-1:0] page_pa
);
  always_comb begin
    if (desc[1])             kind = L2K_SMALL;
    else if (desc[0])        kind = L2K_LARGE;
    else                     kind = L2K_FAULT;
  end

  assign page_pa = (kind == L2K_LARGE) ? join_pa(desc, va, LARGE_LSB)
                                       : join_pa(desc, va, L2_IDX_LSB);
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [VA_W-1:0] req_va,
  input  logic [VA_W-1:0] tbl_base,
  output logic            req_ready,
  output logic            mem_rd_en,
  output logic [VA_W-1:0] mem_rd_addr,
  input  logic            mem_rd_valid,
  input  l1_kind_t        l1_kind,
  input  logic [VA_W-1:0] l1_pa,
  input  logic [VA_W-1:0] l1_next,
  input  l2_kind_t        l2_kind,
  input  logic [VA_W-1:0] l2_pa,
  output logic [VA_W-1:0] va_q,
  output logic            done,
  output logic [VA_W-1:0] pa,
  output logic            fault,
  output logic            fault_stage,
  output logic [VA_W-1:0] fault_va
);
  walk_state_t state;

  // named internal events
  logic accept, resp_l1, resp_l2;
  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign resp_l1   = (state == ST_LVL1) && mem_rd_valid;
  assign resp_l2   = (state == ST_LVL2) && mem_rd_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      mem_rd_en   <= 1'b0;
      mem_rd_addr <= '0;
      va_q        <= '0;
      done        <= 1'b0;
      pa          <= '0;
      fault       <= 1'b0;
      fault_stage <= 1'b0;
      fault_va    <= '0;
    end else begin
      mem_rd_en <= 1'b0;
      done      <= 1'b0;
      unique case (state)
        ST_IDLE: if (accept) begin
          va_q        <= req_va;
          mem_rd_addr <= l1_entry_addr(tbl_base, req_va);
          mem_rd_en   <= 1'b1;
          state       <= ST_LVL1;
        end
        ST_LVL1: if (resp_l1) begin
          unique case (l1_kind)
            L1K_SECTION: begin
              done  <= 1'b1;
              fault <= 1'b0;
              pa    <= l1_pa;
              state <= ST_IDLE;
            end
            L1K_LINK: begin
              mem_rd_addr <= l1_next;
              mem_rd_en   <= 1'b1;
              state       <= ST_LVL2;
            end
            default: begin
              done        <= 1'b1;
              fault       <= 1'b1;
              fault_stage <= 1'b0;
              fault_va    <= va_q;
              state       <= ST_IDLE;
            end
          endcase
        end
        ST_LVL2: if (resp_l2) begin
          done  <= 1'b1;
          state <= ST_IDLE;
          if (l2_kind == L2K_FAULT) begin
            fault       <= 1'b1;
            fault_stage <= 1'b1;
            fault_va    <= va_q;
          end else begin
            fault <= 1'b0;
            pa    <= l2_pa;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2
  accept_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> mem_rd_en &&
      mem_rd_addr[VA_W-1:L1_BASE_LSB] == $past(tbl_base[VA_W-1:L1_BASE_LSB]));

  // R5
  link_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_l1 && l1_kind == L1K_LINK) |=> mem_rd_en && !done && !req_ready);

  // R9
  one_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en);

  // R9
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> !req_ready);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  done_after_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(mem_rd_valid) && req_ready);

  // R4
  l1_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_l1 && l1_kind == L1K_FAULT) |=> done && fault && !fault_stage);

  // R8
  l2_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_l2 && l2_kind == L2K_FAULT) |=> done && fault && fault_stage);

  // R11
  idle_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && !req_valid) |=> !mem_rd_en && !done);
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [31:0] req_va,
  input  logic [31:0] tbl_base,
  output logic        req_ready,
  output logic        mem_rd_en,
  output logic [31:0] mem_rd_addr,
  input  logic        mem_rd_valid,
  input  logic [31:0] mem_rd_data,
  output logic        done,
  output logic [31:0] pa,
  output logic        fault,
  output logic        fault_stage,
  output logic [31:0] fault_va
);
  l1_kind_t        l1_kind;
  l2_kind_t        l2_kind;
  logic [VA_W-1:0] l1_pa, l1_next, l2_pa, va_q;

  ptw_l1_decode u_l1 (
    .desc(mem_rd_data), .va(va_q),
    .kind(l1_kind), .sect_pa(l1_pa), .next_addr(l1_next)
  );

  ptw_l2_decode u_l2 (
    .desc(mem_rd_data), .va(va_q),
    .kind(l2_kind), .page_pa(l2_pa)
  );

  ptw_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_va(req_va), .tbl_base(tbl_base),
    .req_ready(req_ready),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid),
    .l1_kind(l1_kind), .l1_pa(l1_pa), .l1_next(l1_next),
    .l2_kind(l2_kind), .l2_pa(l2_pa),
    .va_q(va_q),
    .done(done), .pa(pa), .fault(fault), .fault_stage(fault_stage), .fault_va(fault_va)
  );
endmodule

// File: tb/ptw_walker_test.sv
module ptw_walker_test;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 2;
  localparam logic [31:0] BASE = 32'h0010_0000;
  localparam int NV = 9;

  localparam logic [31:0] V_VA [NV] = '{32'h0030_0ABC, 32'h0040_0000, 32'h0050_1234,
    32'h0060_7ABC, 32'h0060_8123, 32'h0061_2345, 32'h0061_F00F, 32'h0062_0000, 32'hFFF0_0010};
  localparam logic [31:0] V_PA [NV] = '{32'h1230_0ABC, 32'h0, 32'h0,
    32'h8765_4ABC, 32'h4444_0123, 32'hABCD_2345, 32'hABCD_F00F, 32'h0, 32'hFFF0_0010};
  localparam logic [NV-1:0] V_FLT = 9'b010000110; // bit i = vector i faults
  localparam logic [NV-1:0] V_STG = 9'b010000000;
  localparam int V_RD [NV] = '{1, 1, 1, 2, 2, 2, 2, 2, 1};
  localparam string V_TAG [NV] = '{"R3", "R4", "R4", "R6", "R6", "R7", "R7", "R8", "R3"};

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, mem_rd_valid = 1'b0;
  logic [31:0] req_va = '0, tbl_base = '0, mem_rd_data = '0;
  logic req_ready, mem_rd_en, done, fault, fault_stage;
  logic [31:0] mem_rd_addr, pa, fault_va;

  logic [31:0] mem [logic [31:0]];
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptw_walker uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va), .tbl_base(tbl_base),
    .req_ready(req_ready), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
    .done(done), .pa(pa), .fault(fault), .fault_stage(fault_stage), .fault_va(fault_va)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] lookup(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  // issue one walk; optionally poke a second request while busy
  task automatic walk(input logic [31:0] va, input logic [31:0] base, input bit poke,
                      output logic [31:0] r_pa, output logic r_flt, output logic r_stg,
                      output logic [31:0] r_fva, output int reads, output logic [31:0] first_a,
                      output bit got);
    int wait_c;
    bit pend;
    logic [31:0] pa_addr;
    got = 0; reads = 0; pend = 0; wait_c = 0; first_a = '0; pa_addr = '0;
    r_pa = '0; r_flt = 0; r_stg = 0; r_fva = '0;
    @(negedge clk);
    req_valid = 1; req_va = va; tbl_base = base;
    @(negedge clk);
    req_valid = 0;
    for (int c = 0; c < 40 && !got; c++) begin
      mem_rd_valid = 0;
      if (poke && c == 0) begin req_valid = 1; req_va = 32'h0040_0000; end
      if (poke && c == 1) req_valid = 0;
      if (done) begin
        got = 1; r_pa = pa; r_flt = fault; r_stg = fault_stage; r_fva = fault_va;
      end
      if (mem_rd_en) begin
        reads++;
        if (reads == 1) first_a = mem_rd_addr;
        pend = 1; wait_c = LAT; pa_addr = mem_rd_addr;
      end
      if (pend) begin
        if (wait_c == 0) begin
          mem_rd_valid = 1; mem_rd_data = lookup(pa_addr); pend = 0;
        end else wait_c--;
      end
      if (!got) @(negedge clk);
    end
    req_valid = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %h expected %h", 32'h1, 32'h0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] g_pa, g_fva, g_first, held;
    logic g_flt, g_stg;
    int g_rd;
    bit g_got;

    mem[32'h0010_000C] = 32'h1234_5002;
    mem[32'h0010_0014] = 32'h0000_0003;
    mem[32'h0010_0018] = 32'h0020_0401;
    mem[32'h0020_041C] = 32'h8765_4002;
    mem[32'h0020_0420] = 32'h4444_0003;
    for (int i = 16; i < 32; i++) mem[32'h0020_0400 + i * 4] = 32'hABCD_0001;
    mem[32'h0010_3FFC] = 32'hFFF0_0002;

    repeat (3) @(negedge clk);
    // R1 reset state
    chk(req_ready === 1'b1, "R1 ready", {31'b0, req_ready}, 32'h1);
    chk(done === 1'b0 && mem_rd_en === 1'b0, "R1 idle outputs", {30'b0, done, mem_rd_en}, 32'h0);
    rst_n = 1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      walk(V_VA[v], BASE, 0, g_pa, g_flt, g_stg, g_fva, g_rd, g_first, g_got);
      chk(g_got, {V_TAG[v], " done"}, {31'b0, g_got}, 32'h1);
      // R2 first read address
      chk(g_first == BASE + (V_VA[v] >> 20) * 4, "R2 l1 addr", g_first, BASE + (V_VA[v] >> 20) * 4);
      // R5 and R9: read count per walk
      chk(g_rd == V_RD[v], "R5 reads", g_rd, V_RD[v]);
      chk(g_flt == V_FLT[v], {V_TAG[v], " fault"}, {31'b0, g_flt}, {31'b0, V_FLT[v]});
      if (V_FLT[v]) begin
        chk(g_stg == V_STG[v], {V_TAG[v], " stage"}, {31'b0, g_stg}, {31'b0, V_STG[v]});
        chk(g_fva == V_VA[v], {V_TAG[v], " fault_va"}, g_fva, V_VA[v]);
      end else begin
        chk(g_pa == V_PA[v], {V_TAG[v], " pa"}, g_pa, V_PA[v]);
      end
    end

    // R2 low base bits ignored
    walk(32'h0030_0ABC, 32'h0010_3FFC, 0, g_pa, g_flt, g_stg, g_fva, g_rd, g_first, g_got);
    chk(g_first == 32'h0010_000C, "R2 base low bits", g_first, 32'h0010_000C);
    chk(g_pa == 32'h1230_0ABC && !g_flt, "R2 base low bits pa", g_pa, 32'h1230_0ABC);

    // R10 done lasts one cycle, result held
    held = pa;
    @(negedge clk);
    chk(done === 1'b0, "R10 pulse", {31'b0, done}, 32'h0);
    repeat (3) @(negedge clk);
    chk(pa == held, "R10 hold", pa, held);

    // R11 request while busy ignored
    walk(32'h0060_7ABC, BASE, 1, g_pa, g_flt, g_stg, g_fva, g_rd, g_first, g_got);
    chk(g_pa == 32'h8765_4ABC && !g_flt, "R11 busy req", g_pa, 32'h8765_4ABC);
    chk(g_rd == 2, "R11 busy reads", g_rd, 2);
    @(negedge clk);
    chk(!mem_rd_en && !done, "R11 no second walk", {30'b0, mem_rd_en, done}, 32'h0);

    // R11 stray response while idle ignored
    mem_rd_valid = 1; mem_rd_data = 32'h5555_0002;
    repeat (2) @(negedge clk);
    mem_rd_valid = 0;
    chk(!done && !mem_rd_en && req_ready, "R11 idle resp", {29'b0, done, mem_rd_en, req_ready}, 32'h1);
    chk(pa == 32'h8765_4ABC, "R11 idle pa", pa, 32'h8765_4ABC);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule